// File: doc/BRIEF.md
# Programmable Display Sync Timing Generator

This block produces the raster timing for a parallel display panel from a single interface clock. A set of configuration inputs defines the total line length in interface clocks and the total frame height in lines, both including blanking. They also set the leading blank and the active extent in each direction, the widths of the horizontal and vertical sync pulses, and the number of interface clocks that carry one pixel. The block drives active-high HSYNC and VSYNC, a data-enable strobe, a one-hot strobe that names the pixel component sent in the current clock, and the current column and line position.

Sync widths are given in half interface clocks. An odd count ends the pulse half a clock early, on the falling clock edge, by means of a flop clocked on the falling edge. The trailing blank in each direction is whatever remains of the total after the leading blank and the active extent. Configuration is copied into shadow registers during reset and again on the last clock of every frame, so a frame always runs with one consistent set of values.

Top module: `disp_tg_top`

## Requirements
- R1: While reset is held and in the first clock after its release, column and line are 0, and HSYNC and VSYNC are high (active-high) whenever their widths are non-zero.
- R2: The column counts interface clocks from 0 to line length minus 1 and then wraps to 0. The line advances by one at each column wrap and runs from 0 to frame height minus 1.
- R3: HSYNC starts at column 0 of every line. For a width of W half clocks it is high for ceil(W/2) clocks when sampled a quarter period after the rising edge, and for floor(W/2) clocks when sampled three quarters after it. W = 0 gives no pulse.
- R4: VSYNC starts at column 0 of line 0 and follows the same half-clock rule as R3, with its width counted in interface clocks from frame start, including across line boundaries. Two successive VSYNC starts are therefore line length times frame height clocks apart.
- R5: Data enable is high exactly when the column lies in [horizontal lead, horizontal lead + active width) and the line lies in [vertical lead, vertical lead + active height).
- R6: The component strobe is zero while data enable is low. While data enable is high, exactly bit k is set, where k = (column - horizontal lead) mod P and P is the clocks-per-pixel setting. A setting of 0 counts as 1.
- R7: A configuration change made during a frame has no effect on any output until column 0 of line 0 of the following frame. From that point the new values apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Display interface clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cfg_line_len_i | input | HW | Total line length in interface clocks, blanking included |
| cfg_hsync_hw_i | input | SW | HSYNC width in half clocks |
| cfg_hlead_i | input | HW | Clocks of blank before active data in a line |
| cfg_hact_i | input | HW | Active clocks per line |
| cfg_frame_h_i | input | VW | Total lines per frame, blanking included |
| cfg_vsync_hw_i | input | SW | VSYNC width in half clocks |
| cfg_vlead_i | input | VW | Blank lines before the first active line |
| cfg_vact_i | input | VW | Active lines per frame |
| cfg_cpp_i | input | CW | Interface clocks (components) per pixel |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| comp_stb_o | output | MAX_CPP | One-hot strobe of the current pixel component |
| col_o | output | HW | Current column in interface clocks |
| line_o | output | VW | Current line |

## Verification
The embedded properties assume a line of at least two clocks, so that a half-clock tail cannot repeat in back-to-back cycles. They also assume a clocks-per-pixel setting no larger than MAX_CPP and a configuration that holds steady across the reset release. Every stimulus vector uses lines of nine clocks or more, sync widths shorter than the line, and pixel sizes from 0 to 4, and changes configuration only between clock edges. Sampling happens at both quarter points of each clock, so the half-clock tail of odd widths is seen both present and absent.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;

   localparam int unsigned SPAN_W = 16;

   // True when pos lies in the half-open window [first, first + len).
   function automatic logic in_span(input logic [SPAN_W-1:0] pos,
                                    input logic [SPAN_W-1:0] first,
                                    input logic [SPAN_W-1:0] len);
      logic [SPAN_W:0] stop;
      stop = {1'b0, first} + {1'b0, len};
      return ({1'b0, pos} >= {1'b0, first}) && ({1'b0, pos} < stop);
   endfunction

endpackage

// File: rtl/disp_tg_sync.sv
module disp_tg_sync #(
   parameter int unsigned SW       = 8,
   parameter bit          HALF_RES = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [SW-1:0] width_i,
   output logic          sync_o
);

   localparam logic [SW-1:0] IDX_MAX = '1;

   logic [SW-1:0] idx_q;
   logic [SW-1:0] cur;
   logic [SW-1:0] full;
   logic          main_on;
   logic          tail_cond;
   logic          tail_on;

   assign full = width_i >> 1;
   assign cur  = start_i ? '0 : idx_q;

   // clocks elapsed since the last start, saturating
   always_ff @(posedge clk_i) begin
      if (!rst_ni)               idx_q <= IDX_MAX;
      else if (start_i)          idx_q <= SW'(1);
      else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
   end

   assign main_on   = cur < full;
   assign tail_cond = width_i[0] && (cur == full);

   generate
      if (HALF_RES) begin : g_half
         logic tail_done_q;
         // cuts the tail clock at its falling edge
         always_ff @(negedge clk_i) begin
            if (!rst_ni) tail_done_q <= 1'b0;
            else         tail_done_q <= tail_cond;
         end
         assign tail_on = tail_cond & ~tail_done_q;
      end else begin : g_whole
         assign tail_on = tail_cond;
      end
   endgenerate

   assign sync_o = main_on | tail_on;

   // R3
   tail_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tail_cond |=> !tail_cond);

   // R3
   lead_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(main_on) |-> start_i);

endmodule

// File: rtl/disp_tg_cnt.sv
module disp_tg_cnt #(
   parameter int unsigned HW      = 12,
   parameter int unsigned VW      = 11,
   parameter int unsigned CW      = 3,
   parameter int unsigned MAX_CPP = 4,
   localparam int unsigned CIW    = (MAX_CPP > 1) ? $clog2(MAX_CPP) : 1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [HW-1:0]  line_len_i,
   input  logic [HW-1:0]  hlead_i,
   input  logic [VW-1:0]  frame_h_i,
   input  logic [CW-1:0]  cpp_i,
   output logic [HW-1:0]  col_o,
   output logic [VW-1:0]  line_o,
   output logic [CIW-1:0] comp_o,
   output logic           frame_end_o
);

   logic [HW-1:0]  col_q, col_n;
   logic [VW-1:0]  line_q, line_n;
   logic [CIW-1:0] comp_q, comp_n;
   logic [CW-1:0]  cpp_eff;
   logic           col_wrap, line_wrap, comp_wrap;

   always_comb begin
      if (cpp_i == '0)                   cpp_eff = CW'(1);
      else if (int'(cpp_i) > MAX_CPP)    cpp_eff = CW'(MAX_CPP);
      else                               cpp_eff = cpp_i;
   end

   assign col_wrap  = col_q >= line_len_i - 1'b1;
   assign line_wrap = line_q >= frame_h_i - 1'b1;
   assign comp_wrap = int'(comp_q) >= int'(cpp_eff) - 1;

   always_comb begin
      col_n  = col_wrap ? '0 : col_q + 1'b1;
      line_n = line_q;
      if (col_wrap) line_n = line_wrap ? '0 : line_q + 1'b1;
      if (col_n == '0 || col_n == hlead_i) comp_n = '0;
      else if (comp_wrap)                   comp_n = '0;
      else                                  comp_n = comp_q + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         col_q  <= '0;
         line_q <= '0;
         comp_q <= '0;
      end else begin
         col_q  <= col_n;
         line_q <= line_n;
         comp_q <= comp_n;
      end
   end

   assign col_o       = col_q;
   assign line_o      = line_q;
   assign comp_o      = comp_q;
   assign frame_end_o = col_wrap & line_wrap;

   // R2
   col_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_q < line_len_i);

   // R2
   line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !col_wrap |=> $stable(line_q));

   // R6
   comp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(comp_q) < int'(cpp_eff));

endmodule

// File: rtl/disp_tg_top.sv
module disp_tg_top #(
   parameter int unsigned HW       = 12,
   parameter int unsigned VW       = 11,
   parameter int unsigned SW       = 8,
   parameter int unsigned CW       = 3,
   parameter int unsigned MAX_CPP  = 4,
   parameter bit          HALF_RES = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [HW-1:0]      cfg_line_len_i,
   input  logic [SW-1:0]      cfg_hsync_hw_i,
   input  logic [HW-1:0]      cfg_hlead_i,
   input  logic [HW-1:0]      cfg_hact_i,
   input  logic [VW-1:0]      cfg_frame_h_i,
   input  logic [SW-1:0]      cfg_vsync_hw_i,
   input  logic [VW-1:0]      cfg_vlead_i,
   input  logic [VW-1:0]      cfg_vact_i,
   input  logic [CW-1:0]      cfg_cpp_i,
   output logic               hsync_o,
   output logic               vsync_o,
   output logic               de_o,
   output logic [MAX_CPP-1:0] comp_stb_o,
   output logic [HW-1:0]      col_o,
   output logic [VW-1:0]      line_o
);
   import disp_tg_pkg::*;

   localparam int unsigned CIW = (MAX_CPP > 1) ? $clog2(MAX_CPP) : 1;

   generate
      if (HW > SPAN_W || VW > SPAN_W) begin : g_bad_pos_w
         $error("disp_tg_top: HW and VW must not exceed SPAN_W");
      end
      if (MAX_CPP < 1 || MAX_CPP >= (1 << CW)) begin : g_bad_cpp
         $error("disp_tg_top: MAX_CPP must be 1 .. 2**CW-1");
      end
      if (SW < 2) begin : g_bad_sw
         $error("disp_tg_top: SW must be at least 2");
      end
   endgenerate

   // shadow configuration, frame-synchronous
   logic [HW-1:0] sh_len, sh_hlead, sh_hact;
   logic [VW-1:0] sh_fh, sh_vlead, sh_vact;
   logic [SW-1:0] sh_hsw, sh_vsw;
   logic [CW-1:0] sh_cpp;

   logic [HW-1:0]  col;
   logic [VW-1:0]  line;
   logic [CIW-1:0] comp;
   logic           frame_end;
   logic           de;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || frame_end) begin
         sh_len   <= cfg_line_len_i;
         sh_hlead <= cfg_hlead_i;
         sh_hact  <= cfg_hact_i;
         sh_fh    <= cfg_frame_h_i;
         sh_vlead <= cfg_vlead_i;
         sh_vact  <= cfg_vact_i;
         sh_hsw   <= cfg_hsync_hw_i;
         sh_vsw   <= cfg_vsync_hw_i;
         sh_cpp   <= cfg_cpp_i;
      end
   end

   disp_tg_cnt #(.HW(HW), .VW(VW), .CW(CW), .MAX_CPP(MAX_CPP)) i_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_len_i  (sh_len),
      .hlead_i     (sh_hlead),
      .frame_h_i   (sh_fh),
      .cpp_i       (sh_cpp),
      .col_o       (col),
      .line_o      (line),
      .comp_o      (comp),
      .frame_end_o (frame_end)
   );

   disp_tg_sync #(.SW(SW), .HALF_RES(HALF_RES)) i_hsync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (col == '0),
      .width_i (sh_hsw),
      .sync_o  (hsync_o)
   );

   disp_tg_sync #(.SW(SW), .HALF_RES(HALF_RES)) i_vsync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (col == '0 && line == '0),
      .width_i (sh_vsw),
      .sync_o  (vsync_o)
   );

   assign de = in_span(SPAN_W'(col),  SPAN_W'(sh_hlead), SPAN_W'(sh_hact))
            && in_span(SPAN_W'(line), SPAN_W'(sh_vlead), SPAN_W'(sh_vact));

   generate
      for (genvar k = 0; k < MAX_CPP; k++) begin : g_stb
         assign comp_stb_o[k] = de && (comp == CIW'(k));
      end
   endgenerate

   assign de_o   = de;
   assign col_o  = col;
   assign line_o = line;

   // R6
   stb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      de_o |-> $countones(comp_stb_o) == 1);

   // R6
   stb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !de_o |-> comp_stb_o == '0);

   // R4
   vs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(vsync_o) |-> (col_o == '0 && line_o == '0));

   // R7
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_end |=> ($stable(sh_len) && $stable(sh_fh) && $stable(sh_hsw)
                      && $stable(sh_vsw) && $stable(sh_cpp)));

endmodule

// File: tb/test_disp_tg_top.sv
module test_disp_tg_top;

   typedef struct packed {
      int len;  int hsw; int hlead; int hact;
      int fh;   int vsw; int vlead; int vact;
      int cpp;
   } vec_t;

   localparam int NVEC = 5;
   localparam vec_t VECS [NVEC] = '{
      '{12,  5, 3,  6, 6,  7, 1, 3, 3},
      '{10,  0, 0, 10, 4,  1, 0, 4, 1},
      '{16,  2, 5,  7, 7, 30, 2, 4, 0},
      '{ 9,  1, 2,  4, 5,  4, 4, 1, 4},
      '{20, 13, 8, 12, 3,  0, 0, 3, 2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_len, cfg_hlead, cfg_hact;
   logic [10:0] cfg_fh, cfg_vlead, cfg_vact;
   logic [7:0]  cfg_hsw, cfg_vsw;
   logic [2:0]  cfg_cpp;
   logic        hsync, vsync, de;
   logic [3:0]  stb;
   logic [11:0] col;
   logic [10:0] line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   vec_t drv, act;
   int   m_col, m_line, m_f;

   always #10 clk = ~clk;

   disp_tg_top i_disp_tg_top (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_line_len_i(cfg_len), .cfg_hsync_hw_i(cfg_hsw),
      .cfg_hlead_i(cfg_hlead), .cfg_hact_i(cfg_hact),
      .cfg_frame_h_i(cfg_fh), .cfg_vsync_hw_i(cfg_vsw),
      .cfg_vlead_i(cfg_vlead), .cfg_vact_i(cfg_vact),
      .cfg_cpp_i(cfg_cpp),
      .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
      .comp_stb_o(stb), .col_o(col), .line_o(line)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int actual, input int expected);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
      end
   endtask

   task automatic drive(input vec_t v);
      drv       = v;
      cfg_len   = 12'(v.len);   cfg_hsw  = 8'(v.hsw);
      cfg_hlead = 12'(v.hlead); cfg_hact = 12'(v.hact);
      cfg_fh    = 11'(v.fh);    cfg_vsw  = 8'(v.vsw);
      cfg_vlead = 11'(v.vlead); cfg_vact = 11'(v.vact);
      cfg_cpp   = 3'(v.cpp);
   endtask

   // leaves time at 5 ns after a rising edge: cycle 0 sample point
   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      act = drv; m_col = 0; m_line = 0; m_f = 0;
   endtask

   // one clock: check at +5 and +15, then move to next +5
   task automatic step(input string over);
      int  p, k, e_stb;
      bit  e_de;
      p = (act.cpp == 0) ? 1 : act.cpp;
      e_de = (m_col >= act.hlead) && (m_col < act.hlead + act.hact)
          && (m_line >= act.vlead) && (m_line < act.vlead + act.vact);
      k = e_de ? (m_col - act.hlead) % p : 0;
      e_stb = e_de ? (1 << k) : 0;
      chk(int'(col) == m_col,   over == "" ? "R2" : over, "column", int'(col), m_col);
      chk(int'(line) == m_line, over == "" ? "R2" : over, "line", int'(line), m_line);
      chk(de == e_de,           over == "" ? "R5" : over, "data enable", int'(de), int'(e_de));
      chk(int'(stb) == e_stb,   over == "" ? "R6" : over, "component strobe", int'(stb), e_stb);
      chk(int'(hsync) == int'(m_col < (act.hsw + 1) / 2), over == "" ? "R3" : over,
          "hsync early", int'(hsync), int'(m_col < (act.hsw + 1) / 2));
      chk(int'(vsync) == int'(m_f < (act.vsw + 1) / 2), over == "" ? "R4" : over,
          "vsync early", int'(vsync), int'(m_f < (act.vsw + 1) / 2));
      #10;
      chk(int'(hsync) == int'(m_col < act.hsw / 2), over == "" ? "R3" : over,
          "hsync late", int'(hsync), int'(m_col < act.hsw / 2));
      chk(int'(vsync) == int'(m_f < act.vsw / 2), over == "" ? "R4" : over,
          "vsync late", int'(vsync), int'(m_f < act.vsw / 2));
      @(posedge clk);
      #5;
      if (m_col >= act.len - 1) begin
         m_col = 0;
         if (m_line >= act.fh - 1) begin
            m_line = 0;
            act = drv;
         end else m_line++;
      end else m_col++;
      if (m_col == 0 && m_line == 0) m_f = 0;
      else m_f++;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // table walk: each vector for two frames and a few clocks more
      for (int v = 0; v < NVEC; v++) begin
         drive(VECS[v]);
         do_reset();
         for (int c = 0; c < 2 * VECS[v].len * VECS[v].fh + 3; c++) step("");
      end

      // R1: reset state seen at the ports
      drive(VECS[0]);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #5;
      chk(col == '0 && line == '0, "R1", "position in reset", int'(col) + int'(line), 0);
      chk(hsync && vsync, "R1", "syncs in reset", int'({hsync, vsync}), 3);
      do_reset();
      chk(col == '0 && line == '0, "R1", "position after release", int'(col) + int'(line), 0);
      chk(hsync && vsync, "R1", "syncs after release", int'({hsync, vsync}), 3);

      // R7: change configuration mid-frame, effect only from next frame
      for (int c = 0; c < 30; c++) step("R7");
      drive(VECS[3]);
      for (int c = 0; c < 42 + 2 * 45 + 3; c++) step("R7");
      // and back again from a different frame shape
      drive(VECS[4]);
      for (int c = 0; c < 20 + 2 * 60; c++) step("R7");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule